// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This block is the trap-handling slice of a processor's system control coprocessor. It holds the machine state that governs exception entry and return: a status word, a cause word, the exception return address, the error return address, a free-running counter with its match register, and the load-linked flag. The pipeline presents a synchronous exception request with its code and TLB-refill qualifiers, a non-maskable interrupt request, or a return-from-exception command. In each case the controller updates its state and, one cycle later, drives a one-cycle redirect strobe with the target PC.

The block also acts as the interrupt arbiter. Two software-set pending bits, five level-sensitive external lines and the counter-match timer bit are gathered into an 8-bit pending field. Each bit is masked by its own enable bit. The result is gated by the global enable and by the exception and error levels. An interrupt that survives the gating is taken as an exception with code 0, using the PC the pipeline presents on `pc_in`. Software reaches every register through a select/write-enable/read-data port with a combinational read.

Top module: `xcpt_entry_ctl`

## Requirements
- R1: After reset, Status reads 0x00400004 (boot-vector bit 22 and error level bit 2 set). Cause reads 0, Compare reads 0xFFFFFFFF, the load-linked flag reads 0, and `redir_valid` is low.
- R2: An exception request writes its 5-bit code into Cause bits 6:2 and sets the exception level (Status bit 1). One cycle later it raises `redir_valid` for exactly one cycle.
- R3: When the exception level is 0 at entry, EPC captures `pc_in`, or `pc_in - 4` when `pc_in_delay` is set, and Cause bit 31 records `pc_in_delay`. When the exception level is already 1, EPC and Cause bit 31 keep their values and only the code changes.
- R4: The redirect target is a base plus an offset. The base is 0x80000000 when Status bit 22 is 0 and 0xBFC00200 when it is 1. The offset is 0x000 for a TLB refill, 0x080 for an extended TLB refill and 0x180 otherwise. A refill taken while the exception level is already 1 also uses 0x180.
- R5: Cause bits 15:8 show pending interrupts as {timer, external lines 4..0, software 1..0}. An interrupt is taken only when Status bit 0 (global enable) is 1, both levels are 0, and the pending bits ANDed with the Status 15:8 mask are nonzero. It then enters with code 0, EPC taken from `pc_in`, at base + 0x180.
- R6: A return command with error level 0 redirects to EPC and clears the exception level. With error level 1 it redirects to ErrorEPC and clears only the error level. Either form clears the load-linked flag.
- R7: A non-maskable request redirects to 0xBFC00000, sets the error level and loads ErrorEPC from `pc_in`. It leaves EPC untouched. When several events occur in the same cycle, priority is non-maskable, then exception, then return, then interrupt.
- R8: Count advances by one on every second clock. A software write loads Count and restarts the two-clock phase, so the value written plus k/2 (rounded down) is read k clocks later. The timer bit (Cause bit 15) sets when Count equals Compare and stays set.
- R9: A software write to Compare clears the timer bit.
- R10: The register selects are: 0 Status, 1 Cause, 2 EPC, 3 ErrorEPC, 4 Count, 5 Compare, 6 load-linked flag (bit 0). Select 7 reads 0. A Cause write changes only the software bits 9:8. A write presented in a cycle that takes an event is discarded.
- R11: The two-bit mode field in Status bits 4:3 is stored and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 5 | Exception code for the request |
| exc_tlb_miss | input | 1 | Request is a TLB refill |
| exc_xtlb_miss | input | 1 | Request is an extended TLB refill |
| nmi_req | input | 1 | Non-maskable interrupt / soft reset request |
| eret_req | input | 1 | Return-from-exception command |
| pc_in | input | XLEN | PC of the instruction at the trap point |
| pc_in_delay | input | 1 | That instruction sits in a branch delay slot |
| ext_irq | input | 5 | Level-sensitive external interrupt lines |
| csr_sel | input | 3 | Register select |
| csr_we | input | 1 | Register write enable |
| csr_wdata | input | XLEN | Register write data |
| csr_rdata | output | XLEN | Register read data (combinational) |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | XLEN | Redirect target PC |

## Verification
The assertions assume that every request input is a clean, clock-aligned level held for one cycle. They assume the pipeline's `pc_in` is meaningful in any cycle that may take an interrupt, and that nothing other than the software port alters the registers between an event and the check that follows it. The bench drives every request for exactly one cycle from the falling edge and keeps `pc_in` set to a known value. It deliberately presents a register write in the same cycle as an exception and a non-maskable request alongside an exception, so that the discard and priority rules are exercised within these assumptions. The external lines are changed only while they are masked or the exception level is set, which keeps each interrupt entry tied to one identified stimulus.

// File: rtl/xcpt_pkg.sv
package xcpt_pkg;

  // Register select codes on the software port
  typedef enum logic [2:0] {
    SEL_STATUS  = 3'd0,
    SEL_CAUSE   = 3'd1,
    SEL_EPC     = 3'd2,
    SEL_ERREPC  = 3'd3,
    SEL_COUNT   = 3'd4,
    SEL_COMPARE = 3'd5,
    SEL_LLBIT   = 3'd6,
    SEL_NONE    = 3'd7
  } csr_sel_e;

  // Status bit positions
  localparam int ST_IE     = 0;
  localparam int ST_EXL    = 1;
  localparam int ST_ERL    = 2;
  localparam int ST_KSU_LO = 3;
  localparam int ST_IM_LO  = 8;
  localparam int ST_BEV    = 22;

  // Cause bit positions
  localparam int CA_CODE_LO = 2;
  localparam int CA_IP_LO   = 8;
  localparam int CA_SW_W    = 2;
  localparam int CA_BD      = 31;

  localparam int IP_W   = 8;
  localparam int CODE_W = 5;
  localparam int EXT_W  = IP_W - 3;

  typedef struct packed {
    logic              bev;
    logic [IP_W-1:0]   im;
    logic [1:0]        ksu;
    logic              erl;
    logic              exl;
    logic              ie;
  } status_t;

endpackage

// File: rtl/xcpt_timer.sv
module xcpt_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_wr,
  input  logic         cmp_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count_o,
  output logic [W-1:0] compare_o,
  output logic         hit_o
);

  logic [W-1:0] count_q, count_d;
  logic [W-1:0] compare_q, compare_d;
  logic         phase_q, phase_d;
  logic         hit_q, hit_d;
  logic         cmp_en;

  assign cmp_en = cmp_wr;

  always_comb begin
    count_d = count_q;
    phase_d = ~phase_q;
    if (cnt_wr) begin
      count_d = wdata;
      phase_d = 1'b0;
    end else if (phase_q) begin
      count_d = count_q + W'(1);
    end
  end

  always_comb begin
    compare_d = wdata;
    hit_d     = hit_q;
    if (cmp_wr)                     hit_d = 1'b0;
    else if (count_q == compare_q)  hit_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      phase_q   <= 1'b0;
      compare_q <= '1;
      hit_q     <= 1'b0;
    end else begin
      count_q <= count_d;
      phase_q <= phase_d;
      hit_q   <= hit_d;
      if (cmp_en) compare_q <= compare_d;
    end
  end

  assign count_o   = count_q;
  assign compare_o = compare_q;
  assign hit_o     = hit_q;

  p_cmp_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !hit_o);

  p_match_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_wr && count_q == compare_q) |=> hit_o);

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> ((count_q - $past(count_q)) <= W'(1)));

endmodule

// File: rtl/xcpt_irq_gate.sv
module xcpt_irq_gate #(
  parameter int NEXT = 5,
  parameter int NSW  = 2,
  localparam int NIP = NEXT + NSW + 1
) (
  input  logic [NSW-1:0]  sw_ip,
  input  logic [NEXT-1:0] ext_irq,
  input  logic            timer_hit,
  input  logic [NIP-1:0]  im,
  input  logic            ie,
  input  logic            exl,
  input  logic            erl,
  output logic [NIP-1:0]  ip_o,
  output logic            take_o
);

  logic [NIP-1:0] masked;

  assign ip_o = {timer_hit, ext_irq, sw_ip};

  for (genvar i = 0; i < NIP; i++) begin : g_mask
    assign masked[i] = ip_o[i] & im[i];
  end

  assign take_o = ie & ~exl & ~erl & (|masked);

endmodule

// File: rtl/xcpt_vector_sel.sv
module xcpt_vector_sel #(
  parameter int W = 32,
  parameter logic [W-1:0] BASE_RUN  = W'(32'h8000_0000),
  parameter logic [W-1:0] BASE_BOOT = W'(32'hBFC0_0200),
  parameter logic [W-1:0] VEC_RST   = W'(32'hBFC0_0000)
) (
  input  logic         bev,
  input  logic         nmi,
  input  logic         tlb_miss,
  input  logic         xtlb_miss,
  input  logic         exl,
  output logic [W-1:0] vec_o
);

  localparam logic [W-1:0] OFF_REFILL  = '0;
  localparam logic [W-1:0] OFF_XREFILL = W'(32'h080);
  localparam logic [W-1:0] OFF_GENERAL = W'(32'h180);

  logic [W-1:0] base;
  logic [W-1:0] offset;

  always_comb begin
    base = bev ? BASE_BOOT : BASE_RUN;
    if (exl)            offset = OFF_GENERAL;
    else if (tlb_miss)  offset = OFF_REFILL;
    else if (xtlb_miss) offset = OFF_XREFILL;
    else                offset = OFF_GENERAL;
    vec_o = nmi ? VEC_RST : (base + offset);
  end

endmodule

// File: rtl/xcpt_entry_ctl.sv
module xcpt_entry_ctl
  import xcpt_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [4:0]        exc_code,
  input  logic              exc_tlb_miss,
  input  logic              exc_xtlb_miss,
  input  logic              nmi_req,
  input  logic              eret_req,
  input  logic [XLEN-1:0]   pc_in,
  input  logic              pc_in_delay,
  input  logic [4:0]        ext_irq,
  input  logic [2:0]        csr_sel,
  input  logic              csr_we,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_pc
);

  status_t             status_q, status_d;
  logic                bd_q, bd_d;
  logic [CODE_W-1:0]   code_q, code_d;
  logic [CA_SW_W-1:0]  sw_ip_q, sw_ip_d;
  logic [XLEN-1:0]     epc_q, epc_d;
  logic [XLEN-1:0]     errepc_q, errepc_d;
  logic                epc_en, errepc_en;
  logic                ll_q, ll_d;
  logic                redir_valid_q;
  logic [XLEN-1:0]     redir_pc_q, redir_pc_d;

  logic                ev_nmi, ev_exc, ev_eret, ev_irq, any_ev;
  logic                wr_ok;
  logic                irq_take;
  logic [IP_W-1:0]     ip_w;
  logic [XLEN-1:0]     count_w, compare_w, vec_w;
  logic                timer_hit;
  csr_sel_e            sel;

  assign sel = csr_sel_e'(csr_sel);

  // Event arbitration: NMI > exception > return > interrupt
  assign ev_nmi  = nmi_req;
  assign ev_exc  = exc_req  & ~nmi_req;
  assign ev_eret = eret_req & ~nmi_req & ~exc_req;
  assign ev_irq  = irq_take & ~nmi_req & ~exc_req & ~eret_req;
  assign any_ev  = ev_nmi | ev_exc | ev_eret | ev_irq;
  assign wr_ok   = csr_we & ~any_ev;

  xcpt_timer #(.W(XLEN)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_wr    (wr_ok && sel == SEL_COUNT),
    .cmp_wr    (wr_ok && sel == SEL_COMPARE),
    .wdata     (csr_wdata),
    .count_o   (count_w),
    .compare_o (compare_w),
    .hit_o     (timer_hit)
  );

  xcpt_irq_gate #(.NEXT(EXT_W), .NSW(CA_SW_W)) u_gate (
    .sw_ip     (sw_ip_q),
    .ext_irq   (ext_irq),
    .timer_hit (timer_hit),
    .im        (status_q.im),
    .ie        (status_q.ie),
    .exl       (status_q.exl),
    .erl       (status_q.erl),
    .ip_o      (ip_w),
    .take_o    (irq_take)
  );

  xcpt_vector_sel #(.W(XLEN)) u_vec (
    .bev       (status_q.bev),
    .nmi       (ev_nmi),
    .tlb_miss  (ev_exc & exc_tlb_miss),
    .xtlb_miss (ev_exc & exc_xtlb_miss),
    .exl       (status_q.exl),
    .vec_o     (vec_w)
  );

  // Next-state logic
  always_comb begin
    status_d   = status_q;
    bd_d       = bd_q;
    code_d     = code_q;
    sw_ip_d    = sw_ip_q;
    epc_d      = epc_q;
    errepc_d   = errepc_q;
    ll_d       = ll_q;
    redir_pc_d = vec_w;

    if (wr_ok) begin
      unique case (sel)
        SEL_STATUS: begin
          status_d.bev = csr_wdata[ST_BEV];
          status_d.im  = csr_wdata[ST_IM_LO +: IP_W];
          status_d.ksu = csr_wdata[ST_KSU_LO +: 2];
          status_d.erl = csr_wdata[ST_ERL];
          status_d.exl = csr_wdata[ST_EXL];
          status_d.ie  = csr_wdata[ST_IE];
        end
        SEL_CAUSE:  sw_ip_d  = csr_wdata[CA_IP_LO +: CA_SW_W];
        SEL_EPC:    epc_d    = csr_wdata;
        SEL_ERREPC: errepc_d = csr_wdata;
        SEL_LLBIT:  ll_d     = csr_wdata[0];
        default: ;
      endcase
    end

    if (ev_nmi) begin
      status_d.erl = 1'b1;
      errepc_d     = pc_in;
    end else if (ev_exc || ev_irq) begin
      if (!status_q.exl) begin
        epc_d = pc_in_delay ? (pc_in - XLEN'(4)) : pc_in;
        bd_d  = pc_in_delay;
      end
      status_d.exl = 1'b1;
      code_d       = ev_irq ? '0 : exc_code;
    end else if (ev_eret) begin
      ll_d = 1'b0;
      if (status_q.erl) begin
        status_d.erl = 1'b0;
        redir_pc_d   = errepc_q;
      end else begin
        status_d.exl = 1'b0;
        redir_pc_d   = epc_q;
      end
    end
  end

  assign epc_en    = (epc_d != epc_q);
  assign errepc_en = (errepc_d != errepc_q);

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q      <= '{bev: 1'b1, im: '0, ksu: 2'b00, erl: 1'b1, exl: 1'b0, ie: 1'b0};
      bd_q          <= 1'b0;
      code_q        <= '0;
      sw_ip_q       <= '0;
      epc_q         <= '0;
      errepc_q      <= '0;
      ll_q          <= 1'b0;
      redir_valid_q <= 1'b0;
      redir_pc_q    <= '0;
    end else begin
      status_q      <= status_d;
      bd_q          <= bd_d;
      code_q        <= code_d;
      sw_ip_q       <= sw_ip_d;
      ll_q          <= ll_d;
      redir_valid_q <= any_ev;
      if (epc_en)    epc_q      <= epc_d;
      if (errepc_en) errepc_q   <= errepc_d;
      if (any_ev)    redir_pc_q <= redir_pc_d;
    end
  end

  // Read port
  always_comb begin
    csr_rdata = '0;
    unique case (sel)
      SEL_STATUS: begin
        csr_rdata[ST_BEV]               = status_q.bev;
        csr_rdata[ST_IM_LO +: IP_W]     = status_q.im;
        csr_rdata[ST_KSU_LO +: 2]       = status_q.ksu;
        csr_rdata[ST_ERL]               = status_q.erl;
        csr_rdata[ST_EXL]               = status_q.exl;
        csr_rdata[ST_IE]                = status_q.ie;
      end
      SEL_CAUSE: begin
        csr_rdata[CA_BD]                = bd_q;
        csr_rdata[CA_IP_LO +: IP_W]     = ip_w;
        csr_rdata[CA_CODE_LO +: CODE_W] = code_q;
      end
      SEL_EPC:     csr_rdata = epc_q;
      SEL_ERREPC:  csr_rdata = errepc_q;
      SEL_COUNT:   csr_rdata = count_w;
      SEL_COMPARE: csr_rdata = compare_w;
      SEL_LLBIT:   csr_rdata[0] = ll_q;
      default:     csr_rdata = '0;
    endcase
  end

  assign redir_valid = redir_valid_q;
  assign redir_pc    = redir_pc_q;

  // Assertions
  p_entry_sets_exl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_exc |=> status_q.exl && redir_valid_q && code_q == $past(exc_code));

  p_strobe_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid_q && !any_ev |=> !redir_valid_q);

  p_nested_keeps_epc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_exc || ev_irq) && status_q.exl |=> $stable(epc_q) && $stable(bd_q));

  p_irq_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_irq |=> redir_valid_q && code_q == '0 && status_q.exl);

  p_eret_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eret && !status_q.erl |=> redir_pc_q == $past(epc_q) && !status_q.exl);

  p_eret_clears_ll_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eret |=> !ll_q);

  p_nmi_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nmi |=> redir_pc_q == XLEN'(32'hBFC0_0000) && status_q.erl && $stable(epc_q));

endmodule

// File: tb/xcpt_entry_ctl_tb.sv
module xcpt_entry_ctl_tb;
  import xcpt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_req, exc_tlb_miss, exc_xtlb_miss, nmi_req, eret_req;
  logic [4:0]  exc_code;
  logic [31:0] pc_in;
  logic        pc_in_delay;
  logic [4:0]  ext_irq;
  logic [2:0]  csr_sel;
  logic        csr_we;
  logic [31:0] csr_wdata, csr_rdata;
  logic        redir_valid;
  logic [31:0] redir_pc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xcpt_entry_ctl u_dut (
    .clk(clk), .rst_n(rst_n),
    .exc_req(exc_req), .exc_code(exc_code),
    .exc_tlb_miss(exc_tlb_miss), .exc_xtlb_miss(exc_xtlb_miss),
    .nmi_req(nmi_req), .eret_req(eret_req),
    .pc_in(pc_in), .pc_in_delay(pc_in_delay),
    .ext_irq(ext_irq),
    .csr_sel(csr_sel), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    csr_sel = s;
    #1;
    v = csr_rdata;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    csr_sel = s; csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic fire_exc(input logic [4:0] code, input logic [31:0] pc, input logic dly,
                          input logic tlb, input logic xtlb);
    @(negedge clk);
    exc_req = 1'b1; exc_code = code; pc_in = pc; pc_in_delay = dly;
    exc_tlb_miss = tlb; exc_xtlb_miss = xtlb;
    @(negedge clk);
    exc_req = 1'b0; exc_tlb_miss = 1'b0; exc_xtlb_miss = 1'b0; pc_in_delay = 1'b0;
  endtask

  task automatic fire_eret;
    @(negedge clk);
    eret_req = 1'b1;
    @(negedge clk);
    eret_req = 1'b0;
  endtask

  task automatic fire_nmi(input logic [31:0] pc, input logic with_exc);
    @(negedge clk);
    nmi_req = 1'b1; pc_in = pc; exc_req = with_exc; exc_code = 5'd8;
    @(negedge clk);
    nmi_req = 1'b0; exc_req = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(SEL_STATUS, v);  chk("R1 status reset", v, 32'h0040_0004);
    rd(SEL_CAUSE, v);   chk("R1 cause reset", v, 32'h0);
    rd(SEL_COMPARE, v); chk("R1 compare reset", v, 32'hFFFF_FFFF);
    rd(SEL_LLBIT, v);   chk("R1 llbit reset", v, 32'h0);
    rd(SEL_NONE, v);    chk("R10 select 7 reads zero", v, 32'h0);
    chk("R1 no redirect", {31'b0, redir_valid}, 32'h0);
  endtask

  task automatic t_basic_entry;
    logic [31:0] v;
    wr(SEL_STATUS, 32'h0);
    fire_exc(5'd8, 32'h1000, 1'b0, 1'b0, 1'b0);
    chk("R2 strobe", {31'b0, redir_valid}, 32'h1);
    chk("R4 general vector", redir_pc, 32'h8000_0180);
    rd(SEL_CAUSE, v);  chk("R2 code field", v, 32'h0000_0020);
    rd(SEL_EPC, v);    chk("R3 epc capture", v, 32'h1000);
    rd(SEL_STATUS, v); chk("R2 exl set", v, 32'h2);
    @(negedge clk);
    chk("R2 strobe one cycle", {31'b0, redir_valid}, 32'h0);
  endtask

  task automatic t_nested;
    logic [31:0] v;
    fire_exc(5'd12, 32'h2000, 1'b1, 1'b0, 1'b0);
    chk("R4 nested vector", redir_pc, 32'h8000_0180);
    rd(SEL_EPC, v);   chk("R3 nested epc kept", v, 32'h1000);
    rd(SEL_CAUSE, v); chk("R3 nested bd kept code updated", v, 32'h0000_0030);
    fire_exc(5'd2, 32'h2100, 1'b0, 1'b1, 1'b0);
    chk("R4 refill with exl uses 0x180", redir_pc, 32'h8000_0180);
    fire_eret;
    chk("R6 eret strobe", {31'b0, redir_valid}, 32'h1);
    chk("R6 eret to epc", redir_pc, 32'h1000);
    rd(SEL_STATUS, v); chk("R6 exl cleared", v, 32'h0);
  endtask

  task automatic t_delay_slot;
    logic [31:0] v;
    fire_exc(5'd10, 32'h3004, 1'b1, 1'b0, 1'b0);
    rd(SEL_EPC, v);   chk("R3 delay slot epc", v, 32'h3000);
    rd(SEL_CAUSE, v); chk("R3 bd bit", v, 32'h8000_0028);
    fire_eret;
    chk("R6 eret delay slot", redir_pc, 32'h3000);
  endtask

  task automatic t_vectors;
    fire_exc(5'd2, 32'h5000, 1'b0, 1'b1, 1'b0);
    chk("R4 refill vector", redir_pc, 32'h8000_0000);
    fire_eret;
    fire_exc(5'd3, 32'h5000, 1'b0, 1'b0, 1'b1);
    chk("R4 xrefill vector", redir_pc, 32'h8000_0080);
    fire_eret;
    wr(SEL_STATUS, 32'h0040_0000);
    fire_exc(5'd8, 32'h5000, 1'b0, 1'b0, 1'b0);
    chk("R4 boot general vector", redir_pc, 32'hBFC0_0380);
    fire_eret;
    fire_exc(5'd2, 32'h5000, 1'b0, 1'b1, 1'b0);
    chk("R4 boot refill vector", redir_pc, 32'hBFC0_0200);
    fire_eret;
    wr(SEL_STATUS, 32'h0);
  endtask

  task automatic t_ksu;
    logic [31:0] v;
    wr(SEL_STATUS, 32'h0000_0018);
    rd(SEL_STATUS, v); chk("R11 ksu readback", v, 32'h0000_0018);
    wr(SEL_STATUS, 32'h0);
  endtask

  task automatic t_nmi;
    logic [31:0] v;
    wr(SEL_LLBIT, 32'h1);
    rd(SEL_LLBIT, v);  chk("R10 llbit write", v, 32'h1);
    fire_nmi(32'h4444, 1'b1);
    chk("R7 nmi beats exception", redir_pc, 32'hBFC0_0000);
    rd(SEL_STATUS, v); chk("R7 erl set", v, 32'h4);
    rd(SEL_ERREPC, v); chk("R7 errorepc", v, 32'h4444);
    rd(SEL_EPC, v);    chk("R7 epc untouched", v, 32'h5000);
    fire_eret;
    chk("R6 eret to errorepc", redir_pc, 32'h4444);
    rd(SEL_STATUS, v); chk("R6 erl cleared", v, 32'h0);
    rd(SEL_LLBIT, v);  chk("R6 llbit cleared", v, 32'h0);
    fire_exc(5'd8, 32'h6000, 1'b0, 1'b0, 1'b0);
    fire_nmi(32'h7000, 1'b0);
    rd(SEL_STATUS, v); chk("R7 both levels", v, 32'h6);
    fire_eret;
    chk("R6 erl first", redir_pc, 32'h7000);
    rd(SEL_STATUS, v); chk("R6 exl kept under erl", v, 32'h2);
    fire_eret;
    chk("R6 then epc", redir_pc, 32'h6000);
  endtask

  task automatic t_write_discard;
    logic [31:0] v;
    @(negedge clk);
    exc_req = 1'b1; exc_code = 5'd9; pc_in = 32'h8000;
    csr_sel = SEL_EPC; csr_wdata = 32'hDEAD; csr_we = 1'b1;
    @(negedge clk);
    exc_req = 1'b0; csr_we = 1'b0;
    rd(SEL_EPC, v); chk("R10 write discarded in event cycle", v, 32'h8000);
    fire_eret;
    wr(SEL_CAUSE, 32'hFFFF_FFFF);
    rd(SEL_CAUSE, v); chk("R10 cause write only sw bits", v, 32'h0000_0324);
    wr(SEL_CAUSE, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    @(negedge clk);
    ext_irq = 5'b00001; pc_in = 32'h9000;
    #1;
    rd(SEL_CAUSE, v); chk("R5 external pending visible", v, 32'h0000_0424);
    wr(SEL_STATUS, 32'h0000_0400);
    @(negedge clk);
    chk("R5 no take without ie", {31'b0, redir_valid}, 32'h0);
    wr(SEL_STATUS, 32'h0000_0001);
    @(negedge clk);
    chk("R5 no take when masked", {31'b0, redir_valid}, 32'h0);
    wr(SEL_STATUS, 32'h0000_0401);
    @(negedge clk);
    chk("R5 interrupt taken", {31'b0, redir_valid}, 32'h1);
    chk("R5 interrupt vector", redir_pc, 32'h8000_0180);
    rd(SEL_CAUSE, v);  chk("R5 code zero", v, 32'h0000_0400);
    rd(SEL_EPC, v);    chk("R5 epc from pc", v, 32'h9000);
    rd(SEL_STATUS, v); chk("R5 exl on entry", v, 32'h0000_0403);
    ext_irq = 5'b0;
    fire_eret;
    chk("R6 return from interrupt", redir_pc, 32'h9000);
    wr(SEL_CAUSE, 32'h0000_0100);
    @(negedge clk);
    chk("R5 sw bit masked", {31'b0, redir_valid}, 32'h0);
    wr(SEL_STATUS, 32'h0000_0101);
    @(negedge clk);
    chk("R5 sw interrupt taken", {31'b0, redir_valid}, 32'h1);
    wr(SEL_CAUSE, 32'h0);
    fire_eret;
    wr(SEL_STATUS, 32'h0);
  endtask

  task automatic t_timer;
    logic [31:0] v;
    wr(SEL_COUNT, 32'd100);
    rd(SEL_COUNT, v); chk("R8 count load", v, 32'd100);
    for (int i = 0; i < 10; i++) @(negedge clk);
    rd(SEL_COUNT, v); chk("R8 count half rate", v, 32'd105);
    wr(SEL_COMPARE, 32'd108);
    rd(SEL_CAUSE, v); chk("R8 timer not yet", v & 32'h8000, 32'h0);
    for (int i = 0; i < 12; i++) @(negedge clk);
    rd(SEL_CAUSE, v); chk("R8 timer bit on match", v & 32'h8000, 32'h8000);
    for (int i = 0; i < 4; i++) @(negedge clk);
    rd(SEL_CAUSE, v); chk("R8 timer bit held", v & 32'h8000, 32'h8000);
    wr(SEL_COMPARE, 32'hFFFF_0000);
    rd(SEL_CAUSE, v); chk("R9 compare write clears", v & 32'h8000, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    exc_req = 0; exc_code = 0; exc_tlb_miss = 0; exc_xtlb_miss = 0;
    nmi_req = 0; eret_req = 0; pc_in = 0; pc_in_delay = 0; ext_irq = 0;
    csr_sel = 0; csr_we = 0; csr_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic_entry;
    t_nested;
    t_delay_slot;
    t_vectors;
    t_ksu;
    t_nmi;
    t_write_discard;
    t_irq;
    t_timer;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule